// File: doc/BRIEF.md
# Selectless Serial Response Receiver

This block takes in response telegrams that a chain node masters back towards the controller over a two-wire link made of a serial clock and a serial data line, with no select signal. The serial lines are asynchronous to the system clock. Both lines pass through a two-stage synchronizer, and rising clock edges are detected in the system clock domain. The system clock must run at least sixteen times faster than the link bit rate. Data is sampled on rising edges only. The clock may idle low, when the responder is the nearest node, or idle high, when the response travels round the loop from the farthest node. Either case is received without change.

A frame ends when the clock shows no rising edge for two bit periods. At that point the receiver checks the bit count. A good frame is played out of a twelve-byte holding buffer as a stream of bytes, one per cycle, followed by a one-cycle completion pulse that carries the byte count. A bad frame gives only the completion pulse, with an error flag set and a length of zero. A 32-bit counter counts good frames. Reception starts only while the window input is high, and the receiver never drives the link.

The control is a state machine with five states. IDLE waits for the window to open. ARMED waits for the first rising edge, and returns to IDLE if the window closes. SHIFT collects bits until the clock has been dead for a full gap. PLAYOUT emits the buffered bytes. REPORT issues the completion pulse, then returns to ARMED if the window is still open and to IDLE otherwise. The transitions are named open, close, first_edge, gap_good, gap_bad, last_byte and finish.

Top module: `selrx_top`

## Requirements
- R1: After reset, byte_vld, frame_done, err_len and err_ovf are 0 and rx_count is 0.
- R2: With the clock idling low, bits are taken on rising edges, and the first bit of each byte goes to bit 7 of byte_dat (most significant bit first).
- R3: With the clock idling high when the window opens, the same bytes are received and no extra bit is taken from the window opening.
- R4: A frame closes once 2*BIT_CLKS system cycles pass with no rising edge. Its bytes then appear on byte_vld/byte_dat, one per cycle and in arrival order, followed by a single frame_done cycle with frame_len equal to the byte count. Frames separated by such a gap are reported separately.
- R5: A frame of at most 96 bits whose bit count is not a multiple of 8 gives frame_done with err_len=1, err_ovf=0 and frame_len=0, and no byte_vld.
- R6: A frame of more than 96 bits gives frame_done with err_ovf=1, err_len=0 and frame_len=0, and no byte_vld.
- R7: A frame of exactly 96 bits (12 bytes) is accepted in full.
- R8: rx_count rises by one for each frame reported without error, and stays the same for frames with an error.
- R9: cnt_clr clears rx_count at the next edge, and takes priority over an increment in the same cycle.
- R10: Clock edges while en is low start no frame and produce no output.
- R11: byte_vld and frame_done are never high in the same cycle, and the error flags are high only together with frame_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Reception window |
| sclk_in | input | 1 | Serial clock from the link, asynchronous |
| sdat_in | input | 1 | Serial data from the link, asynchronous |
| cnt_clr | input | 1 | Synchronous clear of rx_count |
| byte_vld | output | 1 | A received byte is on byte_dat |
| byte_dat | output | 8 | Received byte |
| frame_done | output | 1 | One-cycle end-of-frame report |
| frame_len | output | 4 | Bytes in the reported frame, 0 on error |
| err_len | output | 1 | Bit count not a multiple of 8 |
| err_ovf | output | 1 | More than 96 bits |
| rx_count | output | 32 | Good-frame counter |

## Verification
The hardest case to reach is a window that opens while the clock is already high. The receiver must not count that level as an edge. Because the synchronizer reset value is low, the first high level seen could easily be mistaken for a rising edge. To reach this case, the bench parks the clock high while the window is closed, then opens the window and sends a frame whose first bit would shift every following byte by one if a phantom edge were taken. Over-length and ragged frames are produced by driving arbitrary bit counts instead of whole bytes.

// File: rtl/selrx_pkg.sv
package selrx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARMED   = 3'd1,
        ST_SHIFT   = 3'd2,
        ST_PLAYOUT = 3'd3,
        ST_REPORT  = 3'd4
    } rx_state_t;

endpackage

// File: rtl/selrx_sync.sv
module selrx_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign d_sync = sync_q;
endmodule

// File: rtl/selrx_edge.sv
module selrx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    // prev_q follows the level at every cycle, so when the window opens it
    // already holds the current idle level and only a later 0->1 counts.
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/selrx_pack.sv
module selrx_pack #(
    parameter int MAX_BYTES = 12,
    localparam int MAX_BITS = MAX_BYTES * 8,
    localparam int BIT_W    = $clog2(MAX_BITS + 2),
    localparam int IDX_W    = $clog2(MAX_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bit_vld,
    input  logic             bit_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [BIT_W-1:0] bit_cnt,
    output logic [7:0]       rd_byte
);
    logic [BIT_W-1:0] cnt_q;
    logic [BIT_W-1:0] cnt_base;
    logic [7:0]       sh_q;
    logic [7:0]       sh_nxt;
    logic [7:0]       mem [MAX_BYTES];
    logic             byte_end;

    assign cnt_base = start ? '0 : cnt_q;
    assign sh_nxt   = {sh_q[6:0], bit_val};
    assign byte_end = bit_vld && (cnt_base[2:0] == 3'd7)
                      && (cnt_base < BIT_W'(MAX_BITS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (bit_vld) begin
            sh_q <= sh_nxt;
            if (cnt_base <= BIT_W'(MAX_BITS)) cnt_q <= cnt_base + 1'b1;
            else                              cnt_q <= cnt_base;
        end
    end

    for (genvar gi = 0; gi < MAX_BYTES; gi++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[gi] <= '0;
            else if (byte_end && (cnt_base[BIT_W-1:3] == (BIT_W-3)'(gi)))
                mem[gi] <= sh_nxt;
        end
    end

    assign bit_cnt = cnt_q;
    assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/selrx_top.sv
module selrx_top
    import selrx_pkg::*;
#(
    parameter int BIT_CLKS  = 16,
    parameter int MAX_BYTES = 12,
    parameter int CNT_W     = 32,
    localparam int MAX_BITS = MAX_BYTES * 8,
    localparam int BIT_W    = $clog2(MAX_BITS + 2),
    localparam int IDX_W    = $clog2(MAX_BYTES),
    localparam int LEN_W    = $clog2(MAX_BYTES + 1),
    localparam int GAP_CYC  = 2 * BIT_CLKS,
    localparam int GAP_W    = $clog2(GAP_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sclk_in,
    input  logic             sdat_in,
    input  logic             cnt_clr,
    output logic             byte_vld,
    output logic [7:0]       byte_dat,
    output logic             frame_done,
    output logic [LEN_W-1:0] frame_len,
    output logic             err_len,
    output logic             err_ovf,
    output logic [CNT_W-1:0] rx_count
);
    rx_state_t        state_q, state_d;
    logic [1:0]       lines_s;
    logic             sclk_s, sdat_s, rise;
    logic [BIT_W-1:0] bit_cnt;
    logic [7:0]       rd_byte;
    logic [GAP_W-1:0] idle_q;
    logic [IDX_W-1:0] rd_q;
    logic [LEN_W-1:0] len_q;
    logic             elen_q, eovf_q;
    logic             gap_hit, ovf_now, ragged_now;
    logic             capture;

    selrx_sync #(.W(2)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sclk_in, sdat_in}),
        .d_sync  (lines_s)
    );
    assign sclk_s = lines_s[1];
    assign sdat_s = lines_s[0];

    selrx_edge i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sclk_s),
        .rise  (rise)
    );

    assign capture = rise && (state_q == ST_ARMED || state_q == ST_SHIFT);

    selrx_pack #(.MAX_BYTES(MAX_BYTES)) i_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (state_q == ST_ARMED),
        .bit_vld (capture),
        .bit_val (sdat_s),
        .rd_idx  (rd_q),
        .bit_cnt (bit_cnt),
        .rd_byte (rd_byte)
    );

    assign gap_hit    = (state_q == ST_SHIFT) && !rise
                        && (idle_q == GAP_W'(GAP_CYC - 1));
    assign ovf_now    = bit_cnt > BIT_W'(MAX_BITS);
    assign ragged_now = !ovf_now && (bit_cnt[2:0] != 3'd0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (en) state_d = ST_ARMED;                       // open
            ST_ARMED:   if (!en) state_d = ST_IDLE;                       // close
                        else if (rise) state_d = ST_SHIFT;                // first_edge
            ST_SHIFT:   if (gap_hit)
                            state_d = (ovf_now || ragged_now) ? ST_REPORT  // gap_bad
                                                              : ST_PLAYOUT; // gap_good
            ST_PLAYOUT: if (LEN_W'(rd_q) == len_q - 1'b1) state_d = ST_REPORT; // last_byte
            ST_REPORT:  state_d = en ? ST_ARMED : ST_IDLE;                // finish
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
            rd_q   <= '0;
            len_q  <= '0;
            elen_q <= 1'b0;
            eovf_q <= 1'b0;
        end else begin
            if (state_q != ST_SHIFT || rise) idle_q <= '0;
            else                             idle_q <= idle_q + 1'b1;

            if (state_q == ST_PLAYOUT) rd_q <= rd_q + 1'b1;
            else                       rd_q <= '0;

            if (gap_hit) begin
                elen_q <= ragged_now;
                eovf_q <= ovf_now;
                len_q  <= (ovf_now || ragged_now) ? '0 : LEN_W'(bit_cnt >> 3);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_count <= '0;
        else if (cnt_clr)
            rx_count <= '0;
        else if (state_q == ST_REPORT && !elen_q && !eovf_q)
            rx_count <= rx_count + 1'b1;
    end

    // outputs
    always_comb begin
        byte_vld   = 1'b0;
        frame_done = 1'b0;
        err_len    = 1'b0;
        err_ovf    = 1'b0;
        byte_dat   = rd_byte;
        frame_len  = len_q;
        unique case (state_q)
            ST_PLAYOUT: byte_vld = 1'b1;
            ST_REPORT: begin
                frame_done = 1'b1;
                err_len    = elen_q;
                err_ovf    = eovf_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/selrx_chk.sv
module selrx_chk #(
    parameter int MAX_BYTES = 12,
    parameter int CNT_W     = 32,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             cnt_clr,
    input logic             byte_vld,
    input logic             frame_done,
    input logic [LEN_W-1:0] frame_len,
    input logic             err_len,
    input logic             err_ovf,
    input logic [CNT_W-1:0] rx_count
);
    AST_VLD_DONE_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && frame_done)); // R11
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_len || err_ovf) |-> frame_done); // R11
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_len && err_ovf)); // R6
    AST_ERR_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && (err_len || err_ovf)) |-> (frame_len == '0)); // R5
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (frame_len <= LEN_W'(MAX_BYTES))); // R7
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (rx_count == '0)); // R9
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && !(frame_done && !err_len && !err_ovf)) |=> $stable(rx_count)); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && frame_done && !err_len && !err_ovf)
        |=> (rx_count == $past(rx_count) + 1'b1)); // R8
    AST_CLOSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en) && !frame_done) |=> !byte_vld); // R10
endmodule

bind selrx_top selrx_chk #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .cnt_clr    (cnt_clr),
    .byte_vld   (byte_vld),
    .frame_done (frame_done),
    .frame_len  (frame_len),
    .err_len    (err_len),
    .err_ovf    (err_ovf),
    .rx_count   (rx_count)
);

// File: tb/test_selrx_top.sv
module test_selrx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        sclk_in = 1'b0;
    logic        sdat_in = 1'b0;
    logic        cnt_clr = 1'b0;
    logic        byte_vld;
    logic [7:0]  byte_dat;
    logic        frame_done;
    logic [3:0]  frame_len;
    logic        err_len;
    logic        err_ovf;
    logic [31:0] rx_count;

    always #10 clk = ~clk;

    selrx_top i_selrx_top (
        .clk(clk), .rst_n(rst_n), .en(en), .sclk_in(sclk_in), .sdat_in(sdat_in),
        .cnt_clr(cnt_clr), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .frame_done(frame_done), .frame_len(frame_len), .err_len(err_len),
        .err_ovf(err_ovf), .rx_count(rx_count)
    );

    typedef struct {
        bit        is_done;
        logic [7:0] d;
        int        len;
        bit        el;
        bit        eo;
        string     rq;
    } item_t;

    item_t      sb[$];
    int         total = 0;
    int         bad = 0;
    int         good_frames = 0;
    bit         ended = 0;
    logic [7:0] fb [16];

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // driver: expected items for a frame of nbits taken from fb
    task automatic expect_frame(input int nbits, input string rq);
        item_t it;
        bit ok;
        ok = (nbits % 8 == 0) && (nbits <= 96);
        if (ok) begin
            for (int i = 0; i < nbits / 8; i++) begin
                it = '{is_done: 0, d: fb[i], len: 0, el: 0, eo: 0, rq: rq};
                sb.push_back(it);
            end
            good_frames++;
        end
        it = '{is_done: 1, d: 8'h00, len: ok ? nbits / 8 : 0,
               el: (nbits <= 96) && (nbits % 8 != 0), eo: nbits > 96, rq: rq};
        sb.push_back(it);
    endtask

    task automatic send(input bit idle_hi, input int nbits);
        for (int k = 0; k < nbits; k++) begin
            if (idle_hi) begin
                sclk_in = 1'b0;
                sdat_in = fb[k / 8][7 - (k % 8)];
                repeat (8) @(negedge clk);
                sclk_in = 1'b1;
                repeat (8) @(negedge clk);
            end else begin
                sdat_in = fb[k / 8][7 - (k % 8)];
                repeat (8) @(negedge clk);
                sclk_in = 1'b1;
                repeat (8) @(negedge clk);
                sclk_in = 1'b0;
            end
        end
        repeat (70) @(negedge clk);
    endtask

    task automatic frame(input bit idle_hi, input int nbits, input string rq);
        expect_frame(nbits, rq);
        send(idle_hi, nbits);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            if (byte_vld) begin
                if (sb.size() == 0 || sb[0].is_done) begin
                    chk(0, "R10", "unexpected byte", int'(byte_dat), -1);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk(byte_dat == it.d, it.rq, "byte", int'(byte_dat), int'(it.d));
                end
            end
            if (frame_done) begin
                if (sb.size() == 0 || !sb[0].is_done) begin
                    chk(0, "R4", "unexpected frame_done", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk(int'(frame_len) == it.len, it.rq, "frame_len", int'(frame_len), it.len);
                    chk(err_len == it.el, it.rq, "err_len", int'(err_len), int'(it.el));
                    chk(err_ovf == it.eo, it.rq, "err_ovf", int'(err_ovf), int'(it.eo));
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(byte_vld == 0 && frame_done == 0, "R1", "outputs in reset", int'(byte_vld | frame_done), 0);
        chk(err_len == 0 && err_ovf == 0, "R1", "error flags in reset", int'(err_len | err_ovf), 0);
        chk(rx_count == 0, "R1", "rx_count in reset", int'(rx_count), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10: edges with window closed are ignored
        fb[0] = 8'hFF;
        send(0, 8);
        chk(rx_count == 0, "R10", "count after closed-window edges", int'(rx_count), 0);
        chk(sb.size() == 0, "R10", "pending items", sb.size(), 0);

        // R2 / R4: idle-low clock, two frames split by the gap
        en = 1'b1;
        repeat (4) @(negedge clk);
        fb[0] = 8'hC5; fb[1] = 8'h3A; fb[2] = 8'h01; fb[3] = 8'h80;
        frame(0, 32, "R2");
        fb[0] = 8'h96; fb[1] = 8'h4B;
        frame(0, 16, "R4");

        // R3: clock parked high before the window opens
        en = 1'b0;
        repeat (4) @(negedge clk);
        sclk_in = 1'b1;
        repeat (6) @(negedge clk);
        en = 1'b1;
        repeat (4) @(negedge clk);
        fb[0] = 8'h80; fb[1] = 8'h7E; fb[2] = 8'h55; fb[3] = 8'hAA; fb[4] = 8'h0F; fb[5] = 8'hF1;
        frame(1, 48, "R3");

        // R5: ragged bit count
        fb[0] = 8'hE7; fb[1] = 8'h18;
        frame(1, 13, "R5");

        // R6: over-length frame, 104 bits
        for (int i = 0; i < 13; i++) fb[i] = 8'(8'h11 * i + 3);
        frame(1, 104, "R6");

        // R7: exactly 12 bytes, idle-low clock
        en = 1'b0;
        repeat (4) @(negedge clk);
        sclk_in = 1'b0;
        repeat (6) @(negedge clk);
        en = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 12; i++) fb[i] = 8'(8'hA3 ^ (i * 8'h1D));
        frame(0, 96, "R7");

        // R8: only good frames counted (R2, R4, R3, R7)
        chk(rx_count == 32'(good_frames), "R8", "good-frame count", int'(rx_count), good_frames);
        chk(good_frames == 4, "R8", "bench good frames", good_frames, 4);

        // R9: synchronous clear
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        chk(rx_count == 0, "R9", "count after clear", int'(rx_count), 0);
        fb[0] = 8'h42;
        frame(0, 8, "R4");
        chk(rx_count == 1, "R8", "count after clear and one frame", int'(rx_count), 1);

        chk(sb.size() == 0, "R11", "items left over", sb.size(), 0);
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule